// File: doc/BRIEF.md
# VME Slave to Local Bus Bridge

This block sits between a VME backplane slave interface and a local processor bus. It watches the active-low address strobe, the two data strobes and the write line coming from the backplane. When a data transfer cycle opens, it presents an offset address and an active-low read or write strobe to the local side. It then answers the VME master with a data transfer acknowledge, or with a bus-error or retry response when the cycle cannot be served. Everything runs on one clock, nominally 25 ns.

The backplane control lines pass through a multi-flop synchronizer before any decision is taken. The address and write data are stable once the strobes are active, so they are captured when the cycle opens. The upper address bits are compared with a base value to decide whether the cycle belongs to this slave. A local busy input, sampled at the same moment, turns the answer into a retry. Each of the three responses leaves the block as an output-enable. An external open-drain pad pulls the backplane line low while its enable is high.

The local side has no valid/ready pair: the strobe itself is the request, and it is held for a fixed count before the acknowledge. No back-pressure is possible within a cycle. A busy local side is reported only at the cycle's start, by a retry.

Top module: `vme_local_bridge`

## Requirements
- R1: The backplane control inputs pass through a two-stage synchronizer. No output reacts before the third rising clock edge after AS and a data strobe go low, and the local strobe goes active on that third edge.
- R2: A cycle opens only when the address strobe and at least one of the two data strobes are low together. Either one alone leaves all outputs inactive.
- R3: A cycle with the write line high drives loc_rd_n low. A cycle with the write line low drives loc_wr_n low. The two are never low together. loc_addr carries the low 15 address bits captured at cycle start, and loc_wdata carries the write data captured at cycle start.
- R4: dtack_oe rises exactly ACK_DLY (3) clock edges after the local strobe goes low.
- R5: On a read, vme_data_out holds the loc_rdata value and vme_data_oe rises on the same edge as dtack_oe. On a write, vme_data_oe stays low.
- R6: When both data strobes return high, the local strobe and every response enable are released together on the third rising edge after the release.
- R7: If loc_busy is high when an in-range cycle opens, retry_oe is asserted on the third edge and no local strobe is issued.
- R8: If the upper 17 address bits differ from BASE (default 0x000A5), berr_oe is asserted on the third edge and no local strobe is issued. An out-of-range address takes priority over busy.
- R9: At most one of dtack_oe, berr_oe and retry_oe is high at any time.
- R10: If the data strobes are released before the acknowledge is due, the local strobe is released and dtack_oe never rises for that cycle.
- R11: After reset, both local strobes are high and every enable (dtack, berr, retry, data) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vme_as_n | input | 1 | Backplane address strobe, active low |
| vme_ds_n | input | 2 | Backplane data strobes, active low |
| vme_write_n | input | 1 | Backplane write line, low for write |
| vme_addr | input | 32 | Backplane address |
| vme_data_in | input | 32 | Data from master on writes |
| vme_data_out | output | 32 | Data to master on reads |
| vme_data_oe | output | 1 | Enable for the read data drivers |
| dtack_oe | output | 1 | Pull acknowledge line low |
| berr_oe | output | 1 | Pull bus-error line low |
| retry_oe | output | 1 | Pull retry line low |
| loc_busy | input | 1 | Local side cannot take a cycle now |
| loc_addr | output | 15 | Local offset address |
| loc_rd_n | output | 1 | Local read strobe, active low |
| loc_wr_n | output | 1 | Local write strobe, active low |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data |

## Verification
Every input change is applied on a falling edge, so the synchronizer puts the first result on the third rising edge after it. The local strobe or the error response is due there, and the acknowledge and read data three edges later. The release of strobe and response is due on the third rising edge after the data strobes go high. The bench counts rising edges from each stimulus and samples on the falling edge just after the due edge. It also samples one edge earlier to show that nothing moved too soon. The early-release case is timed so the release reaches the controller on the very edge the acknowledge would have been due.

// File: rtl/vme_bridge_pkg.sv
package vme_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_ACK,
    ST_FAULT
  } bridge_state_t;
endpackage

// File: rtl/vme_bridge_sync.sv
module vme_bridge_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '1;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vme_bridge_decode.sv
module vme_bridge_decode #(
  parameter int VME_AW = 32,
  parameter int LOC_AW = 15,
  parameter logic [VME_AW-LOC_AW-1:0] BASE = '0
) (
  input  logic [VME_AW-1:0] addr,
  output logic              hit,
  output logic [LOC_AW-1:0] offset
);
  localparam int BW = VME_AW - LOC_AW;

  logic [BW-1:0] upper;
  assign upper  = addr[VME_AW-1:LOC_AW];
  assign hit    = (upper == BASE);
  assign offset = addr[LOC_AW-1:0];
endmodule

// File: rtl/vme_bridge_ctrl.sv
module vme_bridge_ctrl
  import vme_bridge_pkg::*;
#(
  parameter int DW      = 32,
  parameter int LOC_AW  = 15,
  parameter int ACK_DLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n_s,
  input  logic [1:0]        ds_n_s,
  input  logic              write_n_s,
  input  logic              hit,
  input  logic              busy,
  input  logic [LOC_AW-1:0] offset,
  input  logic [DW-1:0]     din,
  input  logic [DW-1:0]     rdata,
  output logic [DW-1:0]     dout,
  output logic              dout_oe,
  output logic              dtack,
  output logic              berr,
  output logic              retry,
  output logic [LOC_AW-1:0] laddr,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DW-1:0]     wdata
);
  localparam int CW = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DLY - 1);

  bridge_state_t st;
  logic [CW-1:0] cnt;
  logic          is_wr;
  logic          ds_idle, start;

  assign ds_idle = &ds_n_s;
  assign start   = !as_n_s && !ds_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      is_wr   <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      dtack   <= 1'b0;
      berr    <= 1'b0;
      retry   <= 1'b0;
      dout    <= '0;
      dout_oe <= 1'b0;
      laddr   <= '0;
      wdata   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            laddr <= offset;
            wdata <= din;
            is_wr <= !write_n_s;
            cnt   <= '0;
            if (!hit) begin
              berr <= 1'b1;
              st   <= ST_FAULT;
            end else if (busy) begin
              retry <= 1'b1;
              st    <= ST_FAULT;
            end else begin
              rd_n <= !write_n_s;
              wr_n <= write_n_s;
              st   <= ST_STROBE;
            end
          end
        end
        ST_STROBE: begin
          if (ds_idle) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
            st   <= ST_IDLE;
          end else if (cnt == LAST) begin
            dtack   <= 1'b1;
            dout    <= rdata;
            dout_oe <= !is_wr;
            st      <= ST_ACK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK, ST_FAULT: begin
          if (ds_idle) begin
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            dtack   <= 1'b0;
            berr    <= 1'b0;
            retry   <= 1'b0;
            dout_oe <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vme_local_bridge.sv
module vme_local_bridge #(
  parameter int VME_AW  = 32,
  parameter int LOC_AW  = 15,
  parameter int DW      = 32,
  parameter int STAGES  = 2,
  parameter int ACK_DLY = 3,
  parameter logic [VME_AW-LOC_AW-1:0] BASE = 'h000A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vme_as_n,
  input  logic [1:0]        vme_ds_n,
  input  logic              vme_write_n,
  input  logic [VME_AW-1:0] vme_addr,
  input  logic [DW-1:0]     vme_data_in,
  output logic [DW-1:0]     vme_data_out,
  output logic              vme_data_oe,
  output logic              dtack_oe,
  output logic              berr_oe,
  output logic              retry_oe,
  input  logic              loc_busy,
  output logic [LOC_AW-1:0] loc_addr,
  output logic              loc_rd_n,
  output logic              loc_wr_n,
  output logic [DW-1:0]     loc_wdata,
  input  logic [DW-1:0]     loc_rdata
);
  logic [3:0]        ctl_raw, ctl_s;
  logic              hit;
  logic [LOC_AW-1:0] offset;

  assign ctl_raw = {vme_as_n, vme_ds_n, vme_write_n};

  vme_bridge_sync #(.W(4), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  vme_bridge_decode #(.VME_AW(VME_AW), .LOC_AW(LOC_AW), .BASE(BASE)) u_dec (
    .addr(vme_addr), .hit(hit), .offset(offset)
  );

  vme_bridge_ctrl #(.DW(DW), .LOC_AW(LOC_AW), .ACK_DLY(ACK_DLY)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .as_n_s(ctl_s[3]), .ds_n_s(ctl_s[2:1]), .write_n_s(ctl_s[0]),
    .hit(hit), .busy(loc_busy), .offset(offset),
    .din(vme_data_in), .rdata(loc_rdata),
    .dout(vme_data_out), .dout_oe(vme_data_oe),
    .dtack(dtack_oe), .berr(berr_oe), .retry(retry_oe),
    .laddr(loc_addr), .rd_n(loc_rd_n), .wr_n(loc_wr_n), .wdata(loc_wdata)
  );
endmodule

// File: rtl/vme_bridge_checker.sv
module vme_bridge_checker #(
  parameter int ACK_DLY = 3
) (
  input logic clk,
  input logic rst_n,
  input logic loc_rd_n,
  input logic loc_wr_n,
  input logic dtack_oe,
  input logic berr_oe,
  input logic retry_oe,
  input logic vme_data_oe
);
  logic       strobe_on;
  logic [7:0] low_cnt;

  assign strobe_on = !loc_rd_n || !loc_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (!strobe_on)       low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!loc_rd_n && !loc_wr_n)); // R3
  AST_ACK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_oe) |-> (low_cnt == 8'(ACK_DLY))); // R4
  AST_DATA_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vme_data_oe |-> (dtack_oe && !loc_rd_n)); // R5
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_oe) |-> (loc_rd_n && loc_wr_n)); // R6
  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_oe || retry_oe) |-> (loc_rd_n && loc_wr_n)); // R7
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dtack_oe, berr_oe, retry_oe}) <= 1); // R9
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dtack_oe |-> strobe_on); // R10
endmodule

bind vme_local_bridge vme_bridge_checker #(.ACK_DLY(ACK_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_rd_n(loc_rd_n), .loc_wr_n(loc_wr_n),
  .dtack_oe(dtack_oe), .berr_oe(berr_oe), .retry_oe(retry_oe),
  .vme_data_oe(vme_data_oe)
);

// File: tb/vme_local_bridge_bench.sv
module vme_local_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vme_as_n = 1'b1;
  logic [1:0]  vme_ds_n = 2'b11;
  logic        vme_write_n = 1'b1;
  logic [31:0] vme_addr = '0;
  logic [31:0] vme_data_in = '0;
  logic [31:0] vme_data_out;
  logic        vme_data_oe, dtack_oe, berr_oe, retry_oe;
  logic        loc_busy = 1'b0;
  logic [14:0] loc_addr;
  logic        loc_rd_n, loc_wr_n;
  logic [31:0] loc_wdata;
  logic [31:0] loc_rdata = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vme_local_bridge u_vme_local_bridge (
    .clk(clk), .rst_n(rst_n), .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n),
    .vme_write_n(vme_write_n), .vme_addr(vme_addr), .vme_data_in(vme_data_in),
    .vme_data_out(vme_data_out), .vme_data_oe(vme_data_oe),
    .dtack_oe(dtack_oe), .berr_oe(berr_oe), .retry_oe(retry_oe),
    .loc_busy(loc_busy), .loc_addr(loc_addr), .loc_rd_n(loc_rd_n),
    .loc_wr_n(loc_wr_n), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [16:0] hi;
    logic [14:0] lo;
    logic [31:0] wdata;
    logic        busy;
    logic [31:0] rdata;
    logic [1:0]  kind;   // 0 ack, 1 bus error, 2 retry
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 17'h000A5, 15'h0010, 32'h0,        1'b0, 32'hDEADBEEF, 2'd0},
    '{1'b1, 17'h000A5, 15'h7FFF, 32'h12345678, 1'b0, 32'h0,        2'd0},
    '{1'b0, 17'h000A4, 15'h0001, 32'h0,        1'b0, 32'h55AA55AA, 2'd1},
    '{1'b1, 17'h000A5, 15'h0100, 32'hCAFEF00D, 1'b1, 32'h0,        2'd2},
    '{1'b0, 17'h1FFFF, 15'h0002, 32'h0,        1'b1, 32'h0,        2'd1},
    '{1'b1, 17'h000A5, 15'h0000, 32'hFFFFFFFF, 1'b0, 32'h0,        2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {loc_rd_n, loc_wr_n, dtack_oe, berr_oe, retry_oe};
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic open_cycle(input vec_t v, input logic [1:0] ds);
    @(negedge clk);
    vme_addr    = {v.hi, v.lo};
    vme_write_n = !v.wr;
    vme_data_in = v.wdata;
    loc_busy    = v.busy;
    loc_rdata   = v.rdata;
    vme_as_n    = 1'b0;
    vme_ds_n    = ds;
  endtask

  task automatic close_cycle(input logic [4:0] held);
    vme_ds_n = 2'b11;
    vme_as_n = 1'b1;
    loc_busy = 1'b0;
    edges(2);
    check("R6 held before release edge", 32'(outs()), 32'(held));
    edges(1);
    check("R6 released on third edge", 32'(outs()), 32'(5'b11000));
    check("R5 data enable dropped", 32'(vme_data_oe), 32'd0);
  endtask

  task automatic run_vec(input vec_t v);
    logic [4:0] held;
    open_cycle(v, 2'b00);
    edges(2);
    check("R1 nothing before third edge", 32'(outs()), 32'(5'b11000));
    edges(1);
    check("R9 one response", 32'($countones({dtack_oe, berr_oe, retry_oe}) <= 1), 32'd1);
    case (v.kind)
      2'd0: begin
        check("R3 strobe select", 32'({loc_rd_n, loc_wr_n}), v.wr ? 32'h2 : 32'h1);
        check("R3 local address", 32'(loc_addr), 32'(v.lo));
        if (v.wr) check("R3 write data", loc_wdata, v.wdata);
        edges(2);
        check("R4 no ack before delay", 32'(dtack_oe), 32'd0);
        edges(1);
        check("R4 ack after three clocks", 32'(dtack_oe), 32'd1);
        check("R5 data enable", 32'(vme_data_oe), 32'(!v.wr));
        if (!v.wr) check("R5 read data", vme_data_out, v.rdata);
        held = v.wr ? 5'b10100 : 5'b01100;
      end
      2'd1: begin
        check("R8 bus error, no strobe", 32'(outs()), 32'(5'b11010));
        held = 5'b11010;
      end
      default: begin
        check("R7 retry, no strobe", 32'(outs()), 32'(5'b11001));
        held = 5'b11001;
      end
    endcase
    close_cycle(held);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    edges(3);
    check("R11 reset outputs", 32'({outs(), vme_data_oe}), 32'(6'b110000));
    @(negedge clk);
    rst_n = 1'b1;
    edges(2);
    check("R11 idle after reset", 32'({outs(), vme_data_oe}), 32'(6'b110000));

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2: address strobe alone, then data strobe alone
    v = VEC[0];
    @(negedge clk);
    vme_addr = {v.hi, v.lo};
    vme_write_n = 1'b1;
    vme_as_n = 1'b0;
    edges(6);
    check("R2 address strobe alone", 32'(outs()), 32'(5'b11000));
    vme_as_n = 1'b1;
    vme_ds_n = 2'b00;
    edges(6);
    check("R2 data strobe alone", 32'(outs()), 32'(5'b11000));
    vme_ds_n = 2'b11;
    edges(4);

    // R2: a single data strobe suffices
    open_cycle(VEC[0], 2'b10);
    edges(3);
    check("R2 one data strobe opens read", 32'({loc_rd_n, loc_wr_n}), 32'h1);
    edges(3);
    check("R4 ack on single strobe", 32'(dtack_oe), 32'd1);
    close_cycle(5'b01100);

    // R10: release before the acknowledge is due
    open_cycle(VEC[0], 2'b00);
    edges(3);
    check("R10 strobe active", 32'(loc_rd_n), 32'd0);
    vme_ds_n = 2'b11;
    vme_as_n = 1'b1;
    edges(2);
    check("R10 strobe held, no ack", 32'({loc_rd_n, dtack_oe}), 32'd0);
    edges(1);
    check("R10 strobe released, no ack", 32'(outs()), 32'(5'b11000));
    edges(3);
    check("R10 ack never rises", 32'(dtack_oe), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule